// File: doc/BRIEF.md
# Dual-Clock Mode-Selected Shift Register

This block holds a 4-bit word (the width is a parameter) on outputs QA..QD, carried on bus `q` with `q[0]` as QA and `q[3]` as QD. It has two separate operation clocks, and a mode level chooses which of them acts. With mode low, a falling edge on the shift clock moves the word one stage from QA toward QD. The serial input enters QA. With mode high, a falling edge on the load clock copies the parallel inputs into the stages: `parIn[0]` goes to QA and `parIn[3]` to QD. Rising edges never change the word. Changing the mode level never changes the word either, whatever levels the two clocks are at.

The whole block runs on one fast system clock. The shift clock, the load clock and the mode level each pass through a two-flop synchronizer. A falling edge is recognised when the previous synchronized sample is 1 and the current one is 0. Mode travels through a synchronizer of the same depth as the clocks, so the mode value used for an operation is the one sampled in the same system cycle as the edge. Serial and parallel data are sampled directly. They must be steady from before the clock edge is applied until the word updates.

A shift toward QA is made outside the block. The outputs are fed back with QB to parallel input A, QC to B and QD to C, and new data is applied at D. The block is then clocked in load mode. One source may drive both operation clocks together.

Top module: `mshr_top`

## Requirements
- R1: With mode low, a falling edge on `shClk` sets QA to `serIn` and sets QB, QC and QD to the previous QA, QB and QC.
- R2: With mode high, a falling edge on `ldClk` sets `q` to `parIn`, with `parIn[0]` going to QA and `parIn[3]` to QD.
- R3: With mode high, `shClk` edges and the `serIn` level have no effect on `q`.
- R4: With mode low, `ldClk` edges have no effect on `q`.
- R5: A rising edge on either operation clock leaves `q` unchanged.
- R6: A change of `modeSel` leaves `q` unchanged in every combination of `shClk` and `ldClk` levels: both low, only `shClk` high, only `ldClk` high, and both high.
- R7: When `shClk` and `ldClk` fall together, only the clock that matches the mode level acts, and at most one operation happens per system cycle.
- R8: With QB wired to `parIn[0]`, QC to `parIn[1]`, QD to `parIn[2]` and new data on `parIn[3]`, each `ldClk` falling edge in mode high moves the word one stage toward QA.
- R9: A synchronous active-high `rst` clears `q` to 0 and clears the stored clock history, so that a clock that is low when reset ends produces no operation.
- R10: `q` changes at the third rising system clock edge after an operation clock falls at the input, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shClk | input | 1 | Shift clock; acts on falling edges when mode is low |
| ldClk | input | 1 | Load clock; acts on falling edges when mode is high |
| modeSel | input | 1 | Mode level: 0 selects shift, 1 selects parallel load |
| serIn | input | 1 | Serial data that enters QA on a shift |
| parIn | input | WIDTH | Parallel data; bit 0 goes to QA |
| q | output | WIDTH | Stored word; bit 0 is QA, bit WIDTH-1 is QD |

## Verification
The assertions check the per-cycle rules on every system cycle. They check that a shift strobe produces exactly the shifted word and that a load strobe produces exactly the parallel inputs. They check that the word holds in any cycle without a strobe, that shift and load are never strobed together, and that the word is zero right after reset. Some properties only show up at the ports over many cycles: which edge and which mode level lead to a strobe, that mode toggles at each clock-level combination are harmless, the three-cycle latency, and the shift toward QA through external feedback. These are shown only by the bench's scenarios, which compare `q` against a model after each clock movement.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  // Strobes from control to datapath, valid for one system cycle.
  typedef struct packed {
    logic doShift;
    logic doLoad;
  } mshr_strobe_t;
endpackage

// File: rtl/mshr_sync.sv
module mshr_sync #(
  parameter int BITS   = 3,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] din,
  output logic [BITS-1:0] dout
);
  logic [STAGES-1:0][BITS-1:0] pipe;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= '0;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/mshr_ctrl.sv
module mshr_ctrl
  import mshr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shClk,
  input  logic         ldClk,
  input  logic         modeSel,
  output mshr_strobe_t strb
);
  localparam int NSIG = 3;
  localparam int IDX_SH = 0;
  localparam int IDX_LD = 1;
  localparam int IDX_MD = 2;

  logic [NSIG-1:0] syncIn, syncOut;
  logic            prevSh, prevLd;
  logic            fallSh, fallLd, modeNow;

  assign syncIn = {modeSel, ldClk, shClk};

  // Mode shares the clock path depth, so it lines up with each edge (R6).
  mshr_sync #(.BITS(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (syncIn),
    .dout (syncOut)
  );

  // Clock history; cleared by reset (R9).
  always_ff @(posedge clk) begin
    if (rst) begin
      prevSh <= 1'b0;
      prevLd <= 1'b0;
    end else begin
      prevSh <= syncOut[IDX_SH];
      prevLd <= syncOut[IDX_LD];
    end
  end

  // Only high-to-low transitions count (R5).
  assign fallSh  = prevSh & ~syncOut[IDX_SH];
  assign fallLd  = prevLd & ~syncOut[IDX_LD];
  assign modeNow = syncOut[IDX_MD];

  // Mode level picks which clock may act (R3, R4, R7).
  always_comb begin
    strb.doShift = fallSh & ~modeNow;
    strb.doLoad  = fallLd &  modeNow;
  end
endmodule

// File: rtl/mshr_data.sv
module mshr_data
  import mshr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  mshr_strobe_t     strb,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] nextQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic shiftSrc;
    if (i == 0) begin : g_head
      assign shiftSrc = serIn;          // R1: serial data enters QA
    end else begin : g_body
      assign shiftSrc = q[i-1];         // R1: stage takes its neighbour toward QA
    end
    always_comb begin
      if (strb.doLoad)       nextQ[i] = parIn[i];   // R2
      else if (strb.doShift) nextQ[i] = shiftSrc;
      else                   nextQ[i] = q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;                   // R9
    else     q <= nextQ;
  end
endmodule

// File: rtl/mshr_top.sv
module mshr_top
  import mshr_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shClk,
  input  logic             ldClk,
  input  logic             modeSel,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q
);
  mshr_strobe_t strb;
  logic         shiftStb, loadStb;

  mshr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .shClk   (shClk),
    .ldClk   (ldClk),
    .modeSel (modeSel),
    .strb    (strb)
  );

  mshr_data #(.WIDTH(WIDTH)) u_data (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .serIn (serIn),
    .parIn (parIn),
    .q     (q)
  );

  assign shiftStb = strb.doShift;
  assign loadStb  = strb.doLoad;
endmodule

// File: rtl/mshr_checker.sv
module mshr_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             serIn,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] q,
  input logic             doShift,
  input logic             doLoad
);
  p_shift_word_r1: assert property (@(posedge clk) disable iff (rst)
    doShift |=> (q == {$past(q[WIDTH-2:0]), $past(serIn)}));

  p_load_word_r2: assert property (@(posedge clk) disable iff (rst)
    doLoad |=> (q == $past(parIn)));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!doShift && !doLoad) |=> $stable(q));

  p_single_op_r7: assert property (@(posedge clk) disable iff (rst)
    !(doShift && doLoad));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == '0));
endmodule

bind mshr_top mshr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .serIn   (serIn),
  .parIn   (parIn),
  .q       (q),
  .doShift (shiftStb),
  .doLoad  (loadStb)
);

// File: tb/sim_mshr_top.sv
module sim_mshr_top;
  localparam int W = 4;
  localparam int SETTLE = 4;
  localparam int NVEC = 9;
  // Vector layout: [11] mode, [10] serial, [9] pulse shClk, [8] pulse ldClk,
  // [7:4] parallel data, [3:0] expected q after the pulse.
  localparam logic [11:0] VEC [NVEC] = '{
    12'b1001_1010_1010,  // R2 load
    12'b1110_1010_1010,  // R3 shift clock ignored in load mode
    12'b0110_0000_0101,  // R1 shift in a 1
    12'b0001_1111_0101,  // R4 load clock ignored in shift mode
    12'b0010_0000_1010,  // R1 shift in a 0
    12'b0110_0000_0101,  // R1
    12'b1011_0011_0011,  // R7 tied clocks, load mode
    12'b0111_0000_0111,  // R7 tied clocks, shift mode
    12'b0010_0000_1110   // R1
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shClk = 1'b0, ldClk = 1'b0, modeSel = 1'b0, serIn = 1'b0;
  logic [W-1:0] parReg = '0;
  logic leftWire = 1'b0, lsIn = 1'b0;
  logic [W-1:0] parIn, q;
  logic [W-1:0] refQ = '0;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign parIn = leftWire ? {lsIn, q[W-1:1]} : parReg;

  mshr_top u0 (
    .clk(clk), .rst(rst), .shClk(shClk), .ldClk(ldClk), .modeSel(modeSel),
    .serIn(serIn), .parIn(parIn), .q(q)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s q=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Reference model for a clock move: only falling edges act.
  task automatic setClocks(input logic c1, input logic c2);
    logic f1, f2;
    logic [W-1:0] par;
    f1 = shClk & ~c1;
    f2 = ldClk & ~c2;
    par = leftWire ? {lsIn, refQ[W-1:1]} : parReg;
    shClk = c1;
    ldClk = c2;
    if (!modeSel && f1) refQ = {refQ[W-2:0], serIn};
    else if (modeSel && f2) refQ = par;
    waitCycles(SETTLE);
  endtask

  task automatic pulse(input string tag, input logic c1, input logic c2);
    setClocks(c1, c2);
    check("R5 rising edge", q, refQ);
    setClocks(1'b0, 1'b0);
    check(tag, q, refQ);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog q=%b expected=%b", q, refQ);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(3);
    check("R9 reset state", q, '0);
    @(negedge clk) rst = 1'b0;
    waitCycles(SETTLE);
    check("R9 no op after reset", q, '0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      modeSel = VEC[v][11];
      serIn   = VEC[v][10];
      parReg  = VEC[v][7:4];
      waitCycles(SETTLE);
      pulse("R1/R2/R3/R4/R7 model", VEC[v][9], VEC[v][8]);
      check("R1/R2/R3/R4/R7 table", q, VEC[v][3:0]);
    end

    // R10 latency: shift mode, serial 1, from 1110 -> 1101
    modeSel = 1'b0; serIn = 1'b1;
    waitCycles(SETTLE);
    shClk = 1'b1;
    waitCycles(SETTLE);
    @(negedge clk);
    shClk = 1'b0;
    refQ = {refQ[W-2:0], serIn};
    waitCycles(2);
    check("R10 not before third edge", q, 4'b1110);
    waitCycles(1);
    check("R10 at third edge", q, 4'b1101);
    check("R10 model", q, refQ);

    // R8 shift toward QA through external wiring
    modeSel = 1'b1; leftWire = 1'b1;
    waitCycles(SETTLE);
    lsIn = 1'b0; pulse("R8 left shift", 1'b0, 1'b1);
    check("R8 value 1", q, 4'b0110);
    lsIn = 1'b0; pulse("R8 left shift", 1'b0, 1'b1);
    check("R8 value 2", q, 4'b0011);
    lsIn = 1'b1; pulse("R8 left shift", 1'b0, 1'b1);
    check("R8 value 3", q, 4'b1001);
    leftWire = 1'b0;

    // R6 mode toggles at each clock level combination
    for (int k = 0; k < 4; k++) begin
      setClocks(k[0], k[1]);
      check("R6 clocks set", q, refQ);
      modeSel = ~modeSel;
      waitCycles(SETTLE);
      check("R6 mode toggle", q, refQ);
      modeSel = ~modeSel;
      waitCycles(SETTLE);
      check("R6 mode toggle back", q, refQ);
      setClocks(1'b0, 1'b0);
      check("R6 clocks low", q, refQ);
    end

    // R3 serial input ignored in load mode
    modeSel = 1'b1; serIn = ~serIn;
    waitCycles(SETTLE);
    check("R3 serial ignored", q, refQ);

    // R9 reset after activity
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    refQ = '0;
    check("R9 reset clears", q, '0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule